// File: doc/BRIEF.md
# Four-Way Set-Associative Read Cache

This block is a read-only cache that sits between a requester and a slower lower memory. Lines are four words wide and each set has four ways. Every way keeps a valid flag, a tag and a line of data. The set field of the read address picks one set. The four stored tags of that set are compared with the address tag at the same time, and the one-hot match vector drives a four-input multiplexer that returns the addressed word.

On a miss the requester is stalled and the block raises a line refill request toward lower memory with the line-aligned address. When the refill is acknowledged, the returned line is written into a chosen way. An empty way is always taken first. When the set is full, the way touched longest ago is replaced. The requester keeps its request and address steady while stalled. The cycle after the refill, the same lookup hits and the word is delivered.

Recency is tracked per set as a 2-bit age for each way. The way just used gets age 0. Every way that was younger than its previous age becomes one step older.

Top module: `assoc4_read_cache`

## Requirements
- R1: Address layout with the default `IDX_W` of 6: bits [1:0] are ignored, bits [3:2] select the word within the line (word k sits at line bits [32k+31:32k]), bits [9:4] select the set, and bits [31:10] are the tag.
- R2: A read whose tag is present and valid in its set gives `rd_valid` high and `rd_stall` low in the same cycle, with `rd_data` equal to the addressed word, and starts no refill.
- R3: A read that misses gives `rd_stall` high in the same cycle. `fill_req` rises on the next cycle with `fill_addr` equal to the read address with bits [3:0] cleared, and both hold steady until a cycle with `fill_ack` high.
- R4: On the clock edge where `fill_req` and `fill_ack` are both high, `fill_data` is stored. A request held through the refill then completes in the following cycle with the correct word.
- R5: Empty ways are filled before any valid line is evicted, so four distinct tags read into one set all hit afterwards.
- R6: When all four ways of a set are valid, a miss replaces the line whose last hit or fill is the oldest. The recency ages of a set always form a permutation, with exactly one way at the oldest age.
- R7: A hit makes its line the most recently used, so a line that was next for eviction survives the following miss.
- R8: After reset every line is invalid: `rd_stall`, `rd_valid` and `fill_req` are low with no request, and the first read of any address misses.
- R9: `rd_stall` and `rd_valid` are never high together, and `fill_req` is high only while `rd_stall` is high.
- R10: Refills and evictions in one set do not disturb lines held in any other set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rd_req | input | 1 | Read request; held with its address while stalled |
| rd_addr | input | ADDR_W | Byte address of the read |
| rd_stall | output | 1 | Request present but not yet served |
| rd_valid | output | 1 | Read served this cycle |
| rd_data | output | WORD_W | Word returned on a served read |
| fill_req | output | 1 | Line refill request to lower memory |
| fill_addr | output | ADDR_W | Line-aligned refill address |
| fill_ack | input | 1 | Refill data valid on `fill_data` |
| fill_data | input | 4*WORD_W | Refill line, word 0 in the low bits |

## Verification
The assertions assume the requester holds `rd_req` and `rd_addr` unchanged from a stalled cycle until the read is served. They also assume that lower memory raises `fill_ack` only while `fill_req` is high and holds it for a single cycle. The stimulus keeps to these rules. Its driver changes the request only after a served cycle. Its refill responder answers each request once, after a fixed delay, with a one-cycle acknowledge. Eviction order is checked only through hit and miss results at the ports, by tracking in the bench the recency sequence that a correct design must follow.

// File: rtl/cache_pkg.sv
package cache_pkg;

    localparam int WAYS       = 4;
    localparam int LINE_WORDS = 4;
    localparam int AGE_W      = $clog2(WAYS);

    typedef logic [$clog2(WAYS)-1:0]           way_t;
    typedef logic [WAYS-1:0]                   way_vec_t;
    typedef logic [AGE_W-1:0]                  age_t;
    typedef logic [WAYS-1:0][AGE_W-1:0]        age_vec_t;

    typedef enum logic {
        S_LOOKUP = 1'b0,
        S_REFILL = 1'b1
    } ctrl_e;

    typedef struct packed {
        logic en;
        way_t way;
    } lru_upd_t;

    function automatic way_t onehot_to_way(way_vec_t v);
        way_t r = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (v[i]) r = r | way_t'(i);
        end
        return r;
    endfunction

    function automatic way_t first_empty(way_vec_t valid);
        way_t r = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (!valid[i]) r = way_t'(i);
        end
        return r;
    endfunction

    function automatic way_t oldest_way(age_vec_t ages);
        way_t r = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (ages[i] == '1) r = way_t'(i);
        end
        return r;
    endfunction

    function automatic way_t pick_victim(way_vec_t valid, age_vec_t ages);
        if (!(&valid)) return first_empty(valid);
        return oldest_way(ages);
    endfunction

    function automatic age_vec_t age_touch(age_vec_t ages, way_t w);
        age_vec_t r;
        age_t     old_age;
        old_age = ages[w];
        for (int i = 0; i < WAYS; i++) begin
            if (way_t'(i) == w)          r[i] = '0;
            else if (ages[i] < old_age)  r[i] = ages[i] + age_t'(1);
            else                         r[i] = ages[i];
        end
        return r;
    endfunction

    function automatic age_vec_t age_start();
        age_vec_t r;
        for (int i = 0; i < WAYS; i++) r[i] = age_t'(i);
        return r;
    endfunction

endpackage

// File: rtl/cache_tag_match.sv
module cache_tag_match
    import cache_pkg::*;
#(
    parameter int TAG_W = 22
) (
    input  way_vec_t                       way_valid,
    input  logic [WAYS-1:0][TAG_W-1:0]     way_tag,
    input  logic [TAG_W-1:0]               look_tag,
    output way_vec_t                       hit_vec,
    output logic                           hit
);

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = way_valid[w] && (way_tag[w] == look_tag);
    end

    assign hit = |hit_vec;

endmodule

// File: rtl/cache_way_mux.sv
module cache_way_mux
    import cache_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic [WAYS-1:0][LINE_WORDS*WORD_W-1:0] lines,
    input  way_vec_t                               sel_vec,
    input  logic [$clog2(LINE_WORDS)-1:0]          word_sel,
    output logic [WORD_W-1:0]                      word_out
);

    logic [WAYS-1:0][WORD_W-1:0] masked;

    for (genvar w = 0; w < WAYS; w++) begin : g_mask
        assign masked[w] = sel_vec[w] ? lines[w][word_sel*WORD_W +: WORD_W] : '0;
    end

    always_comb begin
        word_out = '0;
        for (int w = 0; w < WAYS; w++) word_out = word_out | masked[w];
    end

endmodule

// File: rtl/cache_lru.sv
module cache_lru
    import cache_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  look_set,
    output age_vec_t          look_ages,
    input  lru_upd_t          upd,
    input  logic [IDX_W-1:0]  upd_set
);

    localparam int SETS = 1 << IDX_W;

    age_vec_t ages_q [SETS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) ages_q[s] <= age_start();
        end else if (upd.en) begin
            ages_q[upd_set] <= age_touch(ages_q[upd_set], upd.way);
        end
    end

    assign look_ages = ages_q[look_set];

endmodule

// File: rtl/assoc4_read_cache.sv
module assoc4_read_cache
    import cache_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 6,
    parameter int WORD_W = 32
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         rd_req,
    input  logic [ADDR_W-1:0]            rd_addr,
    output logic                         rd_stall,
    output logic                         rd_valid,
    output logic [WORD_W-1:0]            rd_data,
    output logic                         fill_req,
    output logic [ADDR_W-1:0]            fill_addr,
    input  logic                         fill_ack,
    input  logic [LINE_WORDS*WORD_W-1:0] fill_data
);

    localparam int BYTE_W = $clog2(WORD_W / 8);
    localparam int WSEL_W = $clog2(LINE_WORDS);
    localparam int OFFS_W = BYTE_W + WSEL_W;
    localparam int TAG_W  = ADDR_W - IDX_W - OFFS_W;
    localparam int SETS   = 1 << IDX_W;
    localparam int LINE_W = LINE_WORDS * WORD_W;

    way_vec_t                       valid_q [SETS];
    logic [WAYS-1:0][TAG_W-1:0]     tag_q   [SETS];
    logic [WAYS-1:0][LINE_W-1:0]    data_q  [SETS];

    ctrl_e               state_q;
    logic [IDX_W-1:0]    pend_set_q;
    logic [TAG_W-1:0]    pend_tag_q;
    way_t                pend_way_q;

    logic [IDX_W-1:0]    look_set;
    logic [TAG_W-1:0]    look_tag;
    logic [WSEL_W-1:0]   word_sel;
    logic                unused_byte_bits;
    way_vec_t            hit_vec;
    logic                hit;
    age_vec_t            look_ages;
    way_t                victim;
    logic                refill_done;
    lru_upd_t            lru_upd;
    logic [IDX_W-1:0]    lru_set;

    assign look_set         = rd_addr[OFFS_W +: IDX_W];
    assign look_tag         = rd_addr[ADDR_W-1 -: TAG_W];
    assign word_sel         = rd_addr[BYTE_W +: WSEL_W];
    assign unused_byte_bits = ^rd_addr[BYTE_W-1:0];

    cache_tag_match #(.TAG_W(TAG_W)) u_match (
        .way_valid (valid_q[look_set]),
        .way_tag   (tag_q[look_set]),
        .look_tag  (look_tag),
        .hit_vec   (hit_vec),
        .hit       (hit)
    );

    cache_way_mux #(.WORD_W(WORD_W)) u_mux (
        .lines    (data_q[look_set]),
        .sel_vec  (hit_vec),
        .word_sel (word_sel),
        .word_out (rd_data)
    );

    cache_lru #(.IDX_W(IDX_W)) u_lru (
        .clk       (clk),
        .rst       (rst),
        .look_set  (look_set),
        .look_ages (look_ages),
        .upd       (lru_upd),
        .upd_set   (lru_set)
    );

    assign victim      = pick_victim(valid_q[look_set], look_ages);
    assign rd_valid    = rd_req && hit && (state_q == S_LOOKUP);
    assign rd_stall    = rd_req && !rd_valid;
    assign fill_req    = (state_q == S_REFILL);
    assign fill_addr   = {pend_tag_q, pend_set_q, {OFFS_W{1'b0}}};
    assign refill_done = fill_req && fill_ack;

    always_comb begin
        lru_upd.en  = rd_valid || refill_done;
        lru_upd.way = refill_done ? pend_way_q : onehot_to_way(hit_vec);
        lru_set     = refill_done ? pend_set_q : look_set;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= S_LOOKUP;
            pend_set_q <= '0;
            pend_tag_q <= '0;
            pend_way_q <= '0;
        end else begin
            case (state_q)
                S_LOOKUP: begin
                    if (rd_req && !hit) begin
                        state_q    <= S_REFILL;
                        pend_set_q <= look_set;
                        pend_tag_q <= look_tag;
                        pend_way_q <= victim;
                    end
                end
                S_REFILL: begin
                    if (fill_ack) state_q <= S_LOOKUP;
                end
                default: state_q <= S_LOOKUP;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
        end else if (refill_done) begin
            valid_q[pend_set_q][pend_way_q] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (refill_done) begin
            tag_q[pend_set_q][pend_way_q]  <= pend_tag_q;
            data_q[pend_set_q][pend_way_q] <= fill_data;
        end
    end

endmodule

// File: rtl/assoc4_cache_checker.sv
module assoc4_cache_checker
    import cache_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFFS_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              rd_req,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              rd_stall,
    input logic              rd_valid,
    input logic              fill_req,
    input logic              fill_ack,
    input logic [ADDR_W-1:0] fill_addr,
    input age_vec_t          look_ages
);

    way_vec_t at_oldest;

    always_comb begin
        for (int w = 0; w < WAYS; w++) at_oldest[w] = (look_ages[w] == '1);
    end

    assert_stall_valid_excl_R9: assert property (@(posedge clk) disable iff (rst)
        !(rd_stall && rd_valid));

    assert_fill_under_stall_R9: assert property (@(posedge clk) disable iff (rst)
        fill_req |-> rd_stall);

    assert_fill_aligned_R3: assert property (@(posedge clk) disable iff (rst)
        fill_req |-> (fill_addr[OFFS_W-1:0] == '0));

    assert_fill_held_R3: assert property (@(posedge clk) disable iff (rst)
        (fill_req && !fill_ack) |=> (fill_req && $stable(fill_addr)));

    assert_miss_starts_fill_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_stall && !fill_req) |=> fill_req);

    assert_refill_then_hit_R4: assert property (@(posedge clk) disable iff (rst)
        (fill_req && fill_ack) |=> (!rd_req || !$stable(rd_addr) || rd_valid));

    assert_single_oldest_R6: assert property (@(posedge clk) disable iff (rst)
        $countones(at_oldest) == 1);

endmodule

bind assoc4_read_cache assoc4_cache_checker #(
    .ADDR_W (ADDR_W),
    .OFFS_W (OFFS_W)
) i_checker (
    .clk       (clk),
    .rst       (rst),
    .rd_req    (rd_req),
    .rd_addr   (rd_addr),
    .rd_stall  (rd_stall),
    .rd_valid  (rd_valid),
    .fill_req  (fill_req),
    .fill_ack  (fill_ack),
    .fill_addr (fill_addr),
    .look_ages (look_ages)
);

// File: tb/test_assoc4_read_cache.sv
`timescale 1ns/1ps
module test_assoc4_read_cache;

    localparam int ADDR_W = 32;
    localparam int IDX_W  = 6;
    localparam int WORD_W = 32;
    localparam int LINE_W = 4 * WORD_W;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic              rst = 1'b1;
    logic              rd_req = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic              rd_stall, rd_valid, fill_req;
    logic [WORD_W-1:0] rd_data;
    logic [ADDR_W-1:0] fill_addr;
    logic              fill_ack = 1'b0;
    logic [LINE_W-1:0] fill_data = '0;

    assoc4_read_cache #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .WORD_W(WORD_W)) i_assoc4_read_cache (
        .clk(clk), .rst(rst), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_stall(rd_stall), .rd_valid(rd_valid), .rd_data(rd_data),
        .fill_req(fill_req), .fill_addr(fill_addr),
        .fill_ack(fill_ack), .fill_data(fill_data)
    );

    int checks = 0;
    int errors = 0;
    int fills  = 0;
    bit done   = 1'b0;
    logic [ADDR_W-1:0] last_fill = '0;
    logic [WORD_W-1:0] exp_data_q[$];
    string             exp_req_q[$];

    function automatic logic [WORD_W-1:0] mem_word(logic [ADDR_W-1:0] a);
        return {a[31:2], 2'b00} ^ 32'h5A3C_96E1;
    endfunction

    function automatic logic [ADDR_W-1:0] mk_addr(int tag, int idx, int w);
        return (32'(tag) << (IDX_W + 4)) | (32'(idx) << 4) | (32'(w) << 2);
    endfunction

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // refill responder: answers each request after two cycles with a one-cycle ack
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && fill_req && !fill_ack) begin
                last_fill = fill_addr;
                fills++;
                check(fill_addr[3:0] == 4'h0, "R3", "refill address alignment",
                      fill_addr, {fill_addr[31:4], 4'h0});
                repeat (2) @(posedge clk);
                #1;
                for (int k = 0; k < 4; k++)
                    fill_data[k*WORD_W +: WORD_W] = mem_word({last_fill[31:4], 4'h0} | 32'(k << 2));
                fill_ack = 1'b1;
                @(posedge clk);
                #1;
                fill_ack  = 1'b0;
                fill_data = '0;
            end
        end
    end

    // monitor: scoreboard comparison and handshake exclusivity
    always @(negedge clk) begin
        if (!rst && !done) begin
            check(!(rd_stall && rd_valid), "R9", "stall and valid together",
                  {30'h0, rd_stall, rd_valid}, 32'h0);
            if (fill_req)
                check(rd_stall, "R9", "refill without stall", 32'(rd_stall), 32'h1);
            if (rd_valid) begin
                if (exp_data_q.size() == 0) begin
                    check(1'b0, "R2", "unexpected served read", rd_data, 32'h0);
                end else begin
                    automatic logic [WORD_W-1:0] e = exp_data_q.pop_front();
                    automatic string r = exp_req_q.pop_front();
                    check(rd_data == e, r, "read data", rd_data, e);
                end
            end
        end
    end

    task automatic do_read(int tag, int idx, int w, bit exp_miss, string req);
        automatic int f0 = fills;
        automatic logic [ADDR_W-1:0] a = mk_addr(tag, idx, w);
        exp_data_q.push_back(mem_word(a));
        exp_req_q.push_back(exp_miss ? "R4" : "R2");
        @(posedge clk);
        #1;
        rd_req  = 1'b1;
        rd_addr = a;
        @(negedge clk);
        check(rd_stall == exp_miss, req, "stall on first cycle", 32'(rd_stall), 32'(exp_miss));
        while (!rd_valid) @(negedge clk);
        @(posedge clk);
        #1;
        rd_req = 1'b0;
        check((fills - f0) == (exp_miss ? 1 : 0), req, "refill count",
              32'(fills - f0), exp_miss ? 32'h1 : 32'h0);
        if (exp_miss)
            check(last_fill == {a[31:4], 4'h0}, "R3", "refill address", last_fill, {a[31:4], 4'h0});
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        @(negedge clk);
        check(!rd_stall && !rd_valid && !fill_req, "R8", "idle outputs after reset",
              {29'h0, rd_stall, rd_valid, fill_req}, 32'h0);

        do_read(1, 5, 1, 1'b1, "R8");    // cold miss
        do_read(1, 5, 3, 1'b0, "R1");    // other words of same line
        do_read(1, 5, 0, 1'b0, "R1");
        do_read(1, 5, 2, 1'b0, "R2");
        do_read(1, 6, 2, 1'b1, "R10");   // same tag, other set
        do_read(2, 5, 0, 1'b1, "R5");
        do_read(3, 5, 0, 1'b1, "R5");
        do_read(4, 5, 0, 1'b1, "R5");
        do_read(1, 5, 1, 1'b0, "R5");    // all four resident
        do_read(2, 5, 1, 1'b0, "R5");
        do_read(3, 5, 1, 1'b0, "R5");
        do_read(4, 5, 1, 1'b0, "R5");    // recency oldest..newest: 1 2 3 4
        do_read(1, 5, 2, 1'b0, "R7");    // 1 refreshed: 2 3 4 1
        do_read(5, 5, 0, 1'b1, "R6");    // evicts 2: 3 4 1 5
        do_read(3, 5, 3, 1'b0, "R7");
        do_read(4, 5, 3, 1'b0, "R6");
        do_read(1, 5, 3, 1'b0, "R7");
        do_read(5, 5, 3, 1'b0, "R6");    // 3 4 1 5
        do_read(2, 5, 0, 1'b1, "R6");    // evicts 3: 4 1 5 2
        do_read(3, 5, 0, 1'b1, "R6");    // evicts 4: 1 5 2 3
        do_read(4, 5, 2, 1'b1, "R6");    // evicts 1: 5 2 3 4
        do_read(1, 6, 2, 1'b0, "R10");   // other set untouched
        do_read(1, 5, 0, 1'b1, "R6");    // evicts 5: 2 3 4 1
        do_read(2, 5, 3, 1'b0, "R6");

        repeat (4) @(posedge clk);
        check(exp_data_q.size() == 0, "R2", "scoreboard drained", 32'(exp_data_q.size()), 32'h0);
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL R4 watchdog expired: actual %0d cycles expected fewer", 20000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule